// File: doc/BRIEF.md
# I2C Register-File Target

This block lets an external I2C controller read and write a small register file that lives outside the block. It watches the SCL and SDA lines, each through a two-flop synchroniser clocked by the system clock. It recognises START and STOP conditions and answers one 7-bit chip address. That address is a fixed five-bit prefix followed by two strap inputs, which are captured only while reset is held. The block drives SDA only as an open-drain pull-down enable, so it can acknowledge received bytes and shift out read data.

A write transfer carries the chip address, then a pointer byte, then any number of data bytes. The pointer byte chooses the register index and whether the index advances after each byte. Each data byte becomes a one-cycle write strobe on the register-file port. A read transfer returns the register at the current pointer, MSB first, and keeps returning bytes while the controller acknowledges them. The usual read sequence is a write transfer that sets only the pointer, a STOP or repeated START, then a read transfer that the controller ends with a NO-ACK and a STOP.

Top module: `i2c_regfile_port`

## Requirements
- R1: A START (synchronised SDA falling while SCL is high) restarts byte reception at the chip-address byte, even in the middle of a byte or transfer. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. After reset SDA is released and no write strobe is active.
- R2: Bits 7..1 of the first byte after a START are compared against 1,0,0,1,1,strap[1],strap[0]. Bit 0 is R/W, where 1 means read and 0 means write. On a match the block pulls SDA low during the ninth SCL pulse.
- R3: The strap inputs are sampled only while rst_n is low. Changing them after reset does not change which address is answered.
- R4: If the chip address does not match, the block does not acknowledge it, never pulls SDA low and issues no write strobe until the next START.
- R5: In a write transfer the byte after the chip address is the pointer byte. Bit 7 is the auto-increment flag and bits 6..0 are the register index. The block acknowledges the pointer byte.
- R6: Each further byte of a write transfer produces exactly one single-cycle reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte received MSB first. The block acknowledges each such byte.
- R7: With the flag set, the pointer advances by one, modulo 128, after each written byte and after each read byte the controller acknowledges. With the flag clear, the pointer does not move.
- R8: In a read transfer the block sends reg_rdata for the current pointer MSB first, one bit per SCL pulse, pulling SDA low for each 0 bit.
- R9: After the ninth SCL pulse of a read byte, an acknowledge (SDA low) makes the block send the next byte. A NO-ACK (SDA high) makes it release SDA and drive nothing until the next START or STOP.
- R10: The SDA pull-down enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are captured while low |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Address straps, become the two low chip-address bits |
| reg_addr | output | 7 | Register index (current pointer) |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at reg_addr (combinational read) |

## Verification
The bench sweeps every strap value against every low address pair, with the straps flipped after reset. A block that tracked the live pins, or compared the wrong bits, would acknowledge the wrong address. Pointer wrap from index 127 to 0 is exercised in both directions: an off-by-one or early increment shows up as data in the wrong register or a repeated byte. Repeated and mid-byte STARTs check that a half-received byte is thrown away. A further byte clocked after a NO-ACK, plus bytes sent to a foreign address, catch any leftover drive of SDA or a stray write strobe.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = BYTE_W - 1;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA, ST_IGNORE
  } i2cr_state_e;

  // Compare the received address byte (R/W excluded) against prefix and straps.
  function automatic logic chip_match(input logic [BYTE_W-1:0] rx,
                                      input logic [4:0] prefix,
                                      input logic [1:0] strap);
    return rx[BYTE_W-1:1] == {prefix, strap};
  endfunction

  // Register index step, wrapping at the top of the index space.
  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] idx);
    return idx + IDX_W'(1);
  endfunction
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto import i2cr_pkg::*; #(
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE  = CNT_W'(BYTE_W + 1);

  i2cr_state_e       st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q, rw_q, inc_q, nack_q, oe_q, we_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [IDX_W-1:0]  ptr_q;

  // Named protocol events
  logic rx_state, rx_done, ack_end, addr_ok, ptr_load, wr_fire;
  logic tx_load, tx_shift, tx_release, ack_sample, ptr_step, rd_abort;

  assign rx_state   = st_q inside {ST_ADDR, ST_PTR, ST_WDATA};
  assign rx_done    = rx_state && scl_fall && cnt_q == BITS_DONE && !in_ack_q;
  assign ack_end    = rx_state && scl_fall && in_ack_q;
  assign addr_ok    = chip_match(sh_q, ADDR_PREFIX, strap);
  assign ptr_load   = rx_done && st_q == ST_PTR;
  assign wr_fire    = rx_done && st_q == ST_WDATA;
  assign tx_load    = (ack_end && st_q == ST_ADDR && rw_q) ||
                      (st_q == ST_RDATA && scl_fall && cnt_q == ACK_DONE && !nack_q);
  assign tx_shift   = st_q == ST_RDATA && scl_fall && cnt_q != '0 && cnt_q < BITS_DONE;
  assign tx_release = st_q == ST_RDATA && scl_fall && cnt_q == BITS_DONE;
  assign ack_sample = st_q == ST_RDATA && scl_rise && cnt_q == BITS_DONE;
  assign ptr_step   = inc_q && ((ack_end && st_q == ST_WDATA) || (ack_sample && !sda_s));
  assign rd_abort   = st_q == ST_RDATA && scl_fall && cnt_q == ACK_DONE && nack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; in_ack_q <= 1'b0; rw_q <= 1'b0;
      inc_q <= 1'b0; nack_q <= 1'b0; oe_q <= 1'b0; we_q <= 1'b0;
      sh_q <= '0; tx_q <= '0; ptr_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        st_q <= ST_ADDR; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
      end else begin
        if (rx_state && scl_rise && cnt_q < BITS_DONE) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (rx_done) begin
          if (st_q == ST_ADDR && !addr_ok) begin
            st_q <= ST_IGNORE;
          end else begin
            in_ack_q <= 1'b1;
            oe_q     <= 1'b1;
          end
          if (st_q == ST_ADDR) rw_q <= sh_q[0];
          if (ptr_load) begin
            ptr_q <= sh_q[IDX_W-1:0];
            inc_q <= sh_q[BYTE_W-1];
          end
          if (wr_fire) we_q <= 1'b1;
        end
        if (ack_end) begin
          in_ack_q <= 1'b0;
          oe_q     <= 1'b0;
          cnt_q    <= '0;
          case (st_q)
            ST_ADDR: st_q <= rw_q ? ST_RDATA : ST_PTR;
            ST_PTR:  st_q <= ST_WDATA;
            default: ;
          endcase
        end
        if (ptr_step) ptr_q <= idx_next(ptr_q);
        if (st_q == ST_RDATA && scl_rise && cnt_q < ACK_DONE) cnt_q <= cnt_q + CNT_W'(1);
        if (ack_sample) nack_q <= sda_s;
        if (tx_load) begin
          oe_q   <= ~reg_rdata[BYTE_W-1];
          tx_q   <= {reg_rdata[BYTE_W-2:0], 1'b0};
          cnt_q  <= '0;
          nack_q <= 1'b0;
          st_q   <= ST_RDATA;
        end
        if (tx_shift) begin
          oe_q <= ~tx_q[BYTE_W-1];
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
        if (tx_release) oe_q <= 1'b0;
        if (rd_abort) begin
          st_q <= ST_IGNORE;
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = we_q;

  AST_START_ARMS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR && cnt_q == '0 && !oe_q)); // R1
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !oe_q)); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) |-> (!oe_q && !we_q)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ptr_load) && ptr_q != $past(ptr_q)) |->
      (inc_q && ptr_q == IDX_W'($past(ptr_q) + IDX_W'(1)))); // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s); // R10
endmodule

// File: rtl/i2c_regfile_port.sv
module i2c_regfile_port import i2cr_pkg::*; #(
  parameter logic [4:0]  ADDR_PREFIX = 5'b10011,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] strap_q;
  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;

  // Straps follow the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  i2cr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cr_proto #(.ADDR_PREFIX(ADDR_PREFIX)) proto_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .strap(strap_q), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we)
  );

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q)); // R3
endmodule

// File: tb/i2c_regfile_port_tb_top.sv
`timescale 1ns/1ps
module i2c_regfile_port_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire        sda_bus = sda_m & ~sda_oe;

  logic [7:0] regs [128];
  int n_chk = 0, n_fail = 0, we_cnt = 0, oe_seen = 0, r10_bad = 0;
  logic prev_oe = 1'b0;

  i2c_regfile_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] seed(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction
  function automatic logic [7:0] val(int k);
    return 8'((8'hC3 ^ (k * 17)) & 255);
  endfunction
  function automatic logic [7:0] caddr(logic [1:0] s, logic rd);
    return {5'b10011, s, rd};
  endfunction

  assign reg_rdata = regs[reg_addr];

  // Register-file model and bus monitors, all driven from the ports.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= seed(i);
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (sda_oe) oe_seen <= oe_seen + 1;
    if (sda_oe !== prev_oe && scl) r10_bad <= r10_bad + 1;
    prev_oe <= sda_oe;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic do_reset(logic [1:0] s);
    rst_n = 1'b0; strap = s; scl = 1'b1; sda_m = 1'b1;
    wt(6); rst_n = 1'b1; wt(6);
  endtask
  task automatic bus_start;
    wt(Q/2); sda_m = 1'b1; wt(Q/2); scl = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q/2);
  endtask
  task automatic bus_stop;
    wt(Q/2); sda_m = 1'b0; wt(Q/2); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q/2); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q/2);
    end
  endtask
  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q/2); scl = 1'b1; wt(Q/2); ack = sda_bus; wt(Q/2);
    scl = 1'b0; wt(Q/2);
  endtask
  task automatic recv_byte(logic give_nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q/2); scl = 1'b1; wt(Q/2); b = {b[6:0], sda_bus}; wt(Q/2);
      scl = 1'b0; wt(Q/2);
    end
    sda_m = give_nack; wt(Q/2); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q/2);
    sda_m = 1'b1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic ack, x;
    logic [7:0] b;
    int we0, oe0;

    // R2/R3: every strap value against every low address pair
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      strap = ~2'(s);
      for (int a = 0; a < 4; a++) begin
        bus_start; send_byte(caddr(2'(a), 1'b0), ack); bus_stop;
        check(ack == ((a == s) ? 1'b0 : 1'b1), (a == s) ? "R2 match" : "R3 strap",
              int'(ack), (a == s) ? 0 : 1);
      end
      bus_start; send_byte({5'b10010, 2'(s), 1'b0}, ack); bus_stop;
      check(ack == 1'b1, "R2 prefix", int'(ack), 1);
    end

    do_reset(2'b10);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset", {sda_oe, reg_we}, 0);
    strap = 2'b01;

    // R5/R6/R7: incrementing write across the wrap
    we0 = we_cnt;
    bus_start; send_byte(caddr(2'b10, 1'b0), ack);
    check(ack == 1'b0, "R2 write addr", int'(ack), 0);
    send_byte(8'hFE, ack);
    check(ack == 1'b0, "R5 ptr ack", int'(ack), 0);
    for (int k = 0; k < 4; k++) begin
      send_byte(val(k), ack);
      check(ack == 1'b0, "R6 data ack", int'(ack), 0);
    end
    bus_stop;
    check(we_cnt - we0 == 4, "R6 strobes", we_cnt - we0, 4);
    for (int k = 0; k < 4; k++)
      check(regs[(126 + k) % 128] == val(k), "R7 wrap write",
            int'(regs[(126 + k) % 128]), int'(val(k)));

    // R7: non-incrementing write
    bus_start; send_byte(caddr(2'b10, 1'b0), ack); send_byte(8'h10, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack); bus_stop;
    check(regs[16] == 8'h33, "R7 fixed ptr", int'(regs[16]), 'h33);
    check(regs[17] == seed(17), "R7 neighbour", int'(regs[17]), int'(seed(17)));

    // R8/R9: incrementing read across the wrap, then a byte after NO-ACK
    bus_start; send_byte(caddr(2'b10, 1'b0), ack); send_byte(8'hFE, ack); bus_stop;
    bus_start; send_byte(caddr(2'b10, 1'b1), ack);
    check(ack == 1'b0, "R8 read addr", int'(ack), 0);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k == 3, b);
      check(b == val(k), "R8 read data", int'(b), int'(val(k)));
    end
    oe0 = oe_seen;
    recv_byte(1'b1, b);
    check(b == 8'hFF && oe_seen == oe0, "R9 released", int'(b), 'hFF);
    bus_stop;

    // R7: non-incrementing read repeats one register
    bus_start; send_byte(caddr(2'b10, 1'b0), ack); send_byte(8'h10, ack); bus_stop;
    bus_start; send_byte(caddr(2'b10, 1'b1), ack);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, b);
      check(b == 8'h33, "R7 fixed read", int'(b), 'h33);
    end
    bus_stop;

    // R1: START in mid-byte, then repeated START into a read
    bus_start; send_bits(caddr(2'b10, 1'b0), 3);
    bus_start; send_byte(caddr(2'b10, 1'b0), ack);
    check(ack == 1'b0, "R1 restart", int'(ack), 0);
    send_byte(8'h05, ack);
    bus_start; send_byte(caddr(2'b10, 1'b1), ack);
    recv_byte(1'b1, b);
    check(b == seed(5), "R1 repeated start", int'(b), int'(seed(5)));
    bus_stop;

    // R4: foreign address (current strap pins) is ignored
    we0 = we_cnt; oe0 = oe_seen;
    bus_start; send_byte(caddr(2'b01, 1'b0), ack);
    check(ack == 1'b1, "R4 no ack", int'(ack), 1);
    send_byte(8'h80, x); send_byte(8'h5A, ack); bus_stop;
    check(x == 1'b1 && ack == 1'b1, "R4 later bytes", int'({x, ack}), 3);
    check(we_cnt == we0, "R4 no write", we_cnt - we0, 0);
    check(oe_seen == oe0, "R4 no drive", oe_seen - oe0, 0);
    bus_start; send_byte(caddr(2'b10, 1'b0), ack); bus_stop;
    check(ack == 1'b0, "R4 next start", int'(ack), 0);

    check(r10_bad == 0, "R10 oe while scl high", r10_bad, 0);
    finish_run();
  end
endmodule